// File: doc/BRIEF.md
# Banked Stack Pointer Unit

This block keeps two word-aligned stack pointers, a main pointer and a process pointer. A small control register decides which of the two serves as the current stack pointer. The block also produces the address sequence for stack pushes and pops. It drives no memory itself: for every stacked word it presents one address with a valid strobe, and a companion load/store path performs the transfer.

The mode input chooses the pointer. In handler mode the main pointer is always current. In thread mode, bit 1 of the control register picks the process pointer when set and the main pointer when clear. Reset loads the main pointer from a supplied initial word, which normally comes from the start of the vector table. Either pointer can also be written directly through a select input, so that special-register move operations can reach the pointer that is not current.

The stack is full-descending. A push moves down by one word before each store, and a pop reads at the pointer and then moves up. A single request can move several words. The block walks through them at one address per cycle and writes the pointer back once, when the burst ends.

Top module: `bsp_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the main pointer loads `init_sp` with bits [1:0] cleared. The control register clears to 0 and `addr_valid` drops. After reset the main pointer is current.
- R2: Bits [1:0] of `active_sp`, of `addr_out` and of both stored pointers are always 0. Those bits of any written value are discarded.
- R3: When `handler_mode` is 1, `active_sp` shows the main pointer whatever the control register holds.
- R4: When `handler_mode` is 0, control bit 1 = 0 selects the main pointer and control bit 1 = 1 selects the process pointer.
- R5: When `handler_mode` is 1, `ctl_rdata` reads 0 and writes to the control register are dropped. After a return to thread mode the control register still holds the value it had before.
- R6: Control bit 0 is stored and reads back in thread mode, but it has no effect on pointer selection.
- R7: A request with `req_pop` = 0 and count N (N > 0) is accepted at a clock edge. Starting at that edge, `addr_out` steps through SP−4, SP−8, … SP−4N, one address per cycle, with `addr_valid` high. At the next edge `addr_valid` falls and the pointer used becomes SP−4N.
- R8: A request with `req_pop` = 1 and count N presents the addresses SP, SP+4, … SP+4(N−1), one per cycle. The pointer used then becomes SP+4N at the edge where `addr_valid` falls.
- R9: When `sp_wr_en` is 1 at a clock edge, the pointer named by `sp_wr_sel` is written in any mode. A value of 0 names the main pointer and 1 names the process pointer.
- R10: A request with count 0 is ignored, and so is any request made while `addr_valid` is 1. Neither the addresses nor the pointers change because of it.
- R11: A burst updates the pointer that was current when it was accepted, even if the mode or the control register changes during the burst. A direct write that lands on the same pointer at the completion edge is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_sp | input | ADDR_W | Initial main pointer value loaded during reset |
| handler_mode | input | 1 | 1 = handler mode, 0 = thread mode |
| sp_wr_en | input | 1 | Direct pointer write strobe |
| sp_wr_sel | input | 1 | Direct write target: 0 main, 1 process |
| sp_wr_data | input | ADDR_W | Direct write value |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | 2 | Control register write value |
| req_valid | input | 1 | Push/pop request strobe |
| req_pop | input | 1 | 1 = pop, 0 = push |
| req_count | input | CNT_W | Number of words to move |
| addr_valid | output | 1 | `addr_out` carries a stacked-word address |
| addr_out | output | ADDR_W | Address of the current stacked word |
| active_sp | output | ADDR_W | Current stack pointer value |
| ctl_rdata | output | 2 | Control register read value |

## Verification
The bench walks the worked example of two pushes from 0x20008000 and then the matching pops. A design off by one word in the descending order would put the first word at the pointer itself rather than one word below it.

The bench also checks that a handler-mode control write does not survive the return to thread mode, and that setting bit 0 alone never switches pointers. It checks that a second request during a burst neither restarts the burst nor changes where it ends. The last case switches the control register in the middle of a burst and hits the completion edge with a direct write. A design that re-evaluated the selection late, or let the direct write win, would leave the wrong pointer updated.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
  typedef enum logic {
    PTR_MAIN = 1'b0,
    PTR_PROC = 1'b1
  } ptr_sel_e;
endpackage

// File: rtl/bsp_ctrl.sv
module bsp_ctrl #(
  parameter int CTL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             handler_mode,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  output logic [CTL_W-1:0] rdata,
  output bsp_pkg::ptr_sel_e cur_sel
);
  import bsp_pkg::*;

  logic [CTL_W-1:0] ctl_q;

  always_ff @(posedge clk) begin
    if (rst) ctl_q <= '0;
    else if (wr_en && !handler_mode) ctl_q <= wr_data;
  end

  assign rdata   = handler_mode ? '0 : ctl_q;
  assign cur_sel = (!handler_mode && ctl_q[1]) ? PTR_PROC : PTR_MAIN;

  // R5: a write attempted in handler mode leaves the stored value untouched
  p_handler_write_ignored_r5: assert property (@(posedge clk) disable iff (rst)
    (handler_mode && wr_en) |=> (ctl_q == $past(ctl_q)));
endmodule

// File: rtl/bsp_bank.sv
module bsp_bank
  import bsp_pkg::*;
#(
  parameter int PW = 30
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] init_word,
  input  logic          wr_en,
  input  ptr_sel_e      wr_sel,
  input  logic [PW-1:0] wr_word,
  input  logic          done,
  input  ptr_sel_e      done_sel,
  input  logic [PW-1:0] done_word,
  output logic [PW-1:0] main_word,
  output logic [PW-1:0] proc_word
);
  localparam int NPTR = 2;

  logic [PW-1:0] ptr_q [NPTR];

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (rst) begin
        ptr_q[g] <= (g == 0) ? init_word : '0;
      end else if (done && (int'(done_sel) == g)) begin
        ptr_q[g] <= done_word;
      end else if (wr_en && (int'(wr_sel) == g)) begin
        ptr_q[g] <= wr_word;
      end
    end
  end

  assign main_word = ptr_q[0];
  assign proc_word = ptr_q[1];

  // R11: the burst's final value lands in the pointer it was started on
  p_done_wins_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> ((($past(done_sel) == PTR_MAIN) ? main_word : proc_word) == $past(done_word)));
endmodule

// File: rtl/bsp_seq.sv
module bsp_seq
  import bsp_pkg::*;
#(
  parameter int PW    = 30,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_pop,
  input  logic [CNT_W-1:0] req_count,
  input  logic [PW-1:0]    base_word,
  input  ptr_sel_e         base_sel,
  output logic             addr_valid,
  output logic [PW-1:0]    addr_word,
  output logic             done,
  output ptr_sel_e         done_sel,
  output logic [PW-1:0]    done_word
);
  logic             vld_q;
  logic             pop_q;
  ptr_sel_e         sel_q;
  logic [CNT_W-1:0] rem_q;
  logic [PW-1:0]    addr_q;
  logic             accept;
  logic             last;

  assign accept = req_valid && !vld_q && (req_count != '0);
  assign last   = vld_q && (rem_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      pop_q  <= 1'b0;
      sel_q  <= PTR_MAIN;
      rem_q  <= '0;
      addr_q <= '0;
    end else if (accept) begin
      vld_q  <= 1'b1;
      pop_q  <= req_pop;
      sel_q  <= base_sel;
      rem_q  <= req_count - CNT_W'(1);
      addr_q <= req_pop ? base_word : base_word - PW'(1);
    end else if (last) begin
      vld_q <= 1'b0;
    end else if (vld_q) begin
      rem_q  <= rem_q - CNT_W'(1);
      addr_q <= pop_q ? addr_q + PW'(1) : addr_q - PW'(1);
    end
  end

  assign addr_valid = vld_q;
  assign addr_word  = addr_q;
  assign done       = last;
  assign done_sel   = sel_q;
  assign done_word  = pop_q ? addr_q + PW'(1) : addr_q;

  // R7: successive push addresses descend one word per cycle
  p_push_step_r7: assert property (@(posedge clk) disable iff (rst)
    (vld_q && (rem_q != '0) && !pop_q) |=> (addr_word == $past(addr_word) - PW'(1)));
  // R8: successive pop addresses ascend one word per cycle
  p_pop_step_r8: assert property (@(posedge clk) disable iff (rst)
    (vld_q && (rem_q != '0) && pop_q) |=> (addr_word == $past(addr_word) + PW'(1)));
  // R10: a burst in flight is never restarted by a new request
  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (rst)
    (vld_q && (rem_q != '0)) |=> (vld_q && (rem_q == $past(rem_q) - CNT_W'(1))));
endmodule

// File: rtl/bsp_unit.sv
module bsp_unit #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] init_sp,
  input  logic              handler_mode,
  input  logic              sp_wr_en,
  input  logic              sp_wr_sel,
  input  logic [ADDR_W-1:0] sp_wr_data,
  input  logic              ctl_wr_en,
  input  logic [1:0]        ctl_wr_data,
  input  logic              req_valid,
  input  logic              req_pop,
  input  logic [CNT_W-1:0]  req_count,
  output logic              addr_valid,
  output logic [ADDR_W-1:0] addr_out,
  output logic [ADDR_W-1:0] active_sp,
  output logic [1:0]        ctl_rdata
);
  import bsp_pkg::*;

  localparam int ALIGN_W = 2;
  localparam int PW      = ADDR_W - ALIGN_W;

  ptr_sel_e      cur_sel;
  ptr_sel_e      done_sel;
  logic [PW-1:0] main_word, proc_word, cur_word;
  logic [PW-1:0] addr_word, done_word;
  logic          done;

  bsp_ctrl #(.CTL_W(2)) u_ctrl (
    .clk(clk), .rst(rst), .handler_mode(handler_mode),
    .wr_en(ctl_wr_en), .wr_data(ctl_wr_data),
    .rdata(ctl_rdata), .cur_sel(cur_sel)
  );

  bsp_bank #(.PW(PW)) u_bank (
    .clk(clk), .rst(rst), .init_word(init_sp[ADDR_W-1:ALIGN_W]),
    .wr_en(sp_wr_en), .wr_sel(ptr_sel_e'(sp_wr_sel)),
    .wr_word(sp_wr_data[ADDR_W-1:ALIGN_W]),
    .done(done), .done_sel(done_sel), .done_word(done_word),
    .main_word(main_word), .proc_word(proc_word)
  );

  assign cur_word = (cur_sel == PTR_PROC) ? proc_word : main_word;

  bsp_seq #(.PW(PW), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_pop(req_pop),
    .req_count(req_count), .base_word(cur_word), .base_sel(cur_sel),
    .addr_valid(addr_valid), .addr_word(addr_word),
    .done(done), .done_sel(done_sel), .done_word(done_word)
  );

  assign active_sp = {cur_word, {ALIGN_W{1'b0}}};
  assign addr_out  = {addr_word, {ALIGN_W{1'b0}}};

  // R3: in handler mode the selection settles on the main bank
  p_handler_main_r3: assert property (@(posedge clk) disable iff (rst)
    handler_mode |-> (active_sp[ADDR_W-1:ALIGN_W] == main_word));
endmodule

// File: tb/tb_bsp_unit.sv
module tb_bsp_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] init_sp = 32'h2000_8003;
  logic        handler_mode = 1'b0;
  logic        sp_wr_en = 1'b0;
  logic        sp_wr_sel = 1'b0;
  logic [31:0] sp_wr_data = '0;
  logic        ctl_wr_en = 1'b0;
  logic [1:0]  ctl_wr_data = '0;
  logic        req_valid = 1'b0;
  logic        req_pop = 1'b0;
  logic [3:0]  req_count = '0;
  logic        addr_valid;
  logic [31:0] addr_out, active_sp;
  logic [1:0]  ctl_rdata;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  bsp_unit dut (
    .clk(clk), .rst(rst), .init_sp(init_sp), .handler_mode(handler_mode),
    .sp_wr_en(sp_wr_en), .sp_wr_sel(sp_wr_sel), .sp_wr_data(sp_wr_data),
    .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .req_valid(req_valid), .req_pop(req_pop), .req_count(req_count),
    .addr_valid(addr_valid), .addr_out(addr_out),
    .active_sp(active_sp), .ctl_rdata(ctl_rdata)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected below 100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic ctl_write(input logic [1:0] v);
    @(negedge clk); ctl_wr_en = 1'b1; ctl_wr_data = v;
    @(negedge clk); ctl_wr_en = 1'b0;
  endtask

  task automatic sp_write(input logic sel, input logic [31:0] v);
    @(negedge clk); sp_wr_en = 1'b1; sp_wr_sel = sel; sp_wr_data = v;
    @(negedge clk); sp_wr_en = 1'b0;
  endtask

  task automatic burst(input string tag, input logic pop, input int n, input logic [31:0] base);
    @(negedge clk); req_valid = 1'b1; req_pop = pop; req_count = 4'(n);
    @(negedge clk); req_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      chk({tag, " valid"}, 32'(addr_valid), 32'd1);
      chk({tag, " addr"}, addr_out, pop ? base + 32'(4 * i) : base - 32'(4 * (i + 1)));
      @(negedge clk);
    end
    chk({tag, " end"}, 32'(addr_valid), 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 reset sp", active_sp, 32'h2000_8000);
    chk("R1 reset ctl", 32'(ctl_rdata), 32'd0);
    chk("R1 reset valid", 32'(addr_valid), 32'd0);
  endtask

  task automatic t_push_pop_main;
    burst("R7 push main", 1'b0, 2, 32'h2000_8000);
    chk("R7 push final", active_sp, 32'h2000_7FF8);
    burst("R8 pop main", 1'b1, 2, 32'h2000_7FF8);
    chk("R8 pop final", active_sp, 32'h2000_8000);
  endtask

  task automatic t_direct_proc;
    sp_write(1'b1, 32'h1000_0007);
    chk("R9 main still current", active_sp, 32'h2000_8000);
    ctl_write(2'b10);
    chk("R4 R2 proc selected", active_sp, 32'h1000_0004);
    chk("R4 ctl read", 32'(ctl_rdata), 32'd2);
  endtask

  task automatic t_handler;
    @(negedge clk); handler_mode = 1'b1; ctl_wr_en = 1'b1; ctl_wr_data = 2'b00;
    @(negedge clk); ctl_wr_en = 1'b0;
    chk("R3 handler uses main", active_sp, 32'h2000_8000);
    chk("R5 handler ctl reads 0", 32'(ctl_rdata), 32'd0);
    handler_mode = 1'b0;
    @(negedge clk);
    chk("R5 ctl kept", 32'(ctl_rdata), 32'd2);
    chk("R5 proc again", active_sp, 32'h1000_0004);
  endtask

  task automatic t_bit0;
    ctl_write(2'b01);
    chk("R6 bit0 reads", 32'(ctl_rdata), 32'd1);
    chk("R6 bit0 no switch", active_sp, 32'h2000_8000);
    ctl_write(2'b11);
    chk("R6 ctl 3 reads", 32'(ctl_rdata), 32'd3);
    chk("R6 ctl 3 proc", active_sp, 32'h1000_0004);
  endtask

  task automatic t_push_proc;
    burst("R7 push proc", 1'b0, 3, 32'h1000_0004);
    chk("R7 proc final", active_sp, 32'h0FFF_FFF8);
    @(negedge clk); handler_mode = 1'b1;
    @(negedge clk);
    chk("R7 main untouched", active_sp, 32'h2000_8000);
    handler_mode = 1'b0;
  endtask

  task automatic t_ignore;
    @(negedge clk); req_valid = 1'b1; req_pop = 1'b0; req_count = 4'd0;
    @(negedge clk); req_valid = 1'b0;
    chk("R10 zero count no valid", 32'(addr_valid), 32'd0);
    chk("R10 zero count sp", active_sp, 32'h0FFF_FFF8);
    @(negedge clk); req_valid = 1'b1; req_pop = 1'b0; req_count = 4'd2;
    @(negedge clk); req_pop = 1'b1; req_count = 4'd5;
    chk("R10 busy addr0", addr_out, 32'h0FFF_FFF4);
    @(negedge clk); req_valid = 1'b0;
    chk("R10 busy valid1", 32'(addr_valid), 32'd1);
    chk("R10 busy addr1", addr_out, 32'h0FFF_FFF0);
    @(negedge clk);
    chk("R10 busy end", 32'(addr_valid), 32'd0);
    chk("R10 busy final", active_sp, 32'h0FFF_FFF0);
  endtask

  task automatic t_handler_write;
    @(negedge clk); handler_mode = 1'b1;
    sp_write(1'b0, 32'h3000_0002);
    chk("R9 R2 handler main write", active_sp, 32'h3000_0000);
    handler_mode = 1'b0;
    @(negedge clk);
    chk("R9 proc unchanged", active_sp, 32'h0FFF_FFF0);
  endtask

  task automatic t_midswitch;
    @(negedge clk); req_valid = 1'b1; req_pop = 1'b0; req_count = 4'd2;
    @(negedge clk); req_valid = 1'b0; ctl_wr_en = 1'b1; ctl_wr_data = 2'b00;
    chk("R11 addr0", addr_out, 32'h0FFF_FFEC);
    @(negedge clk); ctl_wr_en = 1'b0;
    sp_wr_en = 1'b1; sp_wr_sel = 1'b1; sp_wr_data = 32'h5555_5550;
    chk("R11 addr1", addr_out, 32'h0FFF_FFE8);
    @(negedge clk); sp_wr_en = 1'b0;
    chk("R11 end", 32'(addr_valid), 32'd0);
    chk("R11 main untouched", active_sp, 32'h3000_0000);
    ctl_write(2'b10);
    chk("R11 proc got burst", active_sp, 32'h0FFF_FFE8);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_push_pop_main();
    t_direct_proc();
    t_handler();
    t_bit0();
    t_push_proc();
    t_ignore();
    t_handler_write();
    t_midswitch();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule